// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor's load/store port and a wide memory port. It keeps recently used 16-byte lines, four 32-bit words each, in a set-associative store with two ways per set. A processor access that finds its line is served in the same cycle. A miss raises the stall output. The block then picks a victim way, copies the victim to memory only if it has been modified, reads the whole missing line and installs it. It then replays the held request, which now hits.

Writes follow a write-back, write-allocate policy. A write hit updates only the cached word and marks the line modified. A write miss first brings the whole line in, and the word is merged when the request is replayed. Each set tracks which of its two ways was touched last, and a miss evicts the other one. An empty way is always used before a valid one is evicted.

The processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady while `cpu_stall` is high. The memory side moves one full line per transfer. The block holds a transfer request steady until the memory returns a one-cycle acknowledge.

Top module: `cache_2way`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses. With no request pending, `cpu_stall` and `mem_req` are both low.
- R2: On a read hit, `cpu_stall` stays low in the cycle of the request, `cpu_rdata` returns the word that address bits [3:2] select, address bits [1:0] have no effect, and no memory transfer starts.
- R3: The set is address bits [7:4] and the tag is bits [31:8] (default 16 sets). Traffic in one set never evicts or writes back a line of another set.
- R4: When a set is full, a miss evicts the way that was less recently hit or filled in that set.
- R5: When a set has an invalid way, a miss fills that way and evicts nothing.
- R6: A write hit marks its line modified. A victim is written to memory only if it is modified. The write (`mem_we`=1, victim line address, the current line contents) precedes the refill read. A clean victim causes no memory write.
- R7: A write miss reads the whole line from memory and then merges the written word. The written word and the untouched words of that line read back correctly afterwards.
- R8: A miss stalls for exactly 2 + L cycles when the victim is clean, or 2 + 2L cycles when it is dirty, where L is the number of cycles each memory transfer lasts up to and including its acknowledge. `mem_addr` is always line-aligned, with bits [3:0] zero.
- R9: Once raised, `mem_req`, `mem_we` and `mem_addr` stay unchanged until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = word write, 0 = word read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Word to write |
| cpu_rdata | output | 32 | Read word, valid when `cpu_req` is high and `cpu_stall` is low |
| cpu_stall | output | 1 | High while the access cannot complete this cycle |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = line write (eviction), 0 = line read (refill) |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line written on eviction, word 0 in bits [31:0] |
| mem_rdata | input | 128 | Line returned on refill, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the current transfer |

## Verification
A directed sequence in one set separates several cases: filling an empty way, a hit that protects a line from eviction, eviction of the older way, and a modified victim versus a clean one. Each case gives a different stall length and a different list of memory transfers. A write miss followed by reads of the written word and of its neighbours shows that the word merge lands after the refill and does not overwrite it. Misses in a second set while the first holds modified lines show that the sets are independent. A long pseudo-random run then covers four tags over four sets. It checks every read word against a flat memory model and every stall length and transfer against a recency model of each set.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    localparam int CW_ADDR_W     = 32;
    localparam int CW_WORD_W     = 32;
    localparam int CW_LINE_WORDS = 4;
    localparam int CW_SETS       = 16;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_WBACK = 2'd1,
        MS_FILL  = 2'd2,
        MS_DONE  = 2'd3
    } miss_state_e;

    // empty way first, otherwise the way the recency bit names
    function automatic logic pick_victim(input logic [1:0] vld, input logic lru);
        if (!vld[0]) return 1'b0;
        if (!vld[1]) return 1'b1;
        return lru;
    endfunction

endpackage

// File: rtl/cache2w_tag_store.sv
module cache2w_tag_store
    import cache2w_pkg::*;
#(
    parameter int SETS  = CW_SETS,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [IDX_W-1:0]       rd_set,
    input  logic [TAG_W-1:0]       rd_tag,
    output logic [1:0]             hit_way,
    output logic [1:0]             way_vld,
    output logic [1:0]             way_dty,
    output logic [1:0][TAG_W-1:0]  way_tag,
    output logic                   lru_way,
    input  logic                   touch_en,
    input  logic                   touch_way,
    input  logic                   touch_dirty,
    input  logic                   fill_en,
    input  logic [IDX_W-1:0]       fill_set,
    input  logic                   fill_way,
    input  logic [TAG_W-1:0]       fill_tag
);

    logic [SETS-1:0] lru_q;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        logic [SETS-1:0]  vld_q;
        logic [SETS-1:0]  dty_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
                dty_q <= '0;
            end else if (fill_en && fill_way == 1'(w)) begin
                vld_q[fill_set] <= 1'b1;
                dty_q[fill_set] <= 1'b0;
            end else if (touch_en && touch_dirty && touch_way == 1'(w)) begin
                dty_q[rd_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && fill_way == 1'(w)) tag_q[fill_set] <= fill_tag;
        end

        assign way_vld[w] = vld_q[rd_set];
        assign way_dty[w] = dty_q[rd_set];
        assign way_tag[w] = tag_q[rd_set];
        assign hit_way[w] = vld_q[rd_set] && (tag_q[rd_set] == rd_tag);
    end

    // lru_q names the way to evict next: the one not just used
    always_ff @(posedge clk) begin
        if (rst)           lru_q <= '0;
        else if (fill_en)  lru_q[fill_set] <= ~fill_way;
        else if (touch_en) lru_q[rd_set]   <= ~touch_way;
    end

    assign lru_way = lru_q[rd_set];

endmodule

// File: rtl/cache2w_data_store.sv
module cache2w_data_store
    import cache2w_pkg::*;
#(
    parameter int SETS       = CW_SETS,
    parameter int WORD_W     = CW_WORD_W,
    parameter int LINE_WORDS = CW_LINE_WORDS,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WSEL_W = $clog2(LINE_WORDS),
    localparam int LINE_W = WORD_W * LINE_WORDS
) (
    input  logic                   clk,
    input  logic [IDX_W-1:0]       rd_set,
    output logic [1:0][LINE_W-1:0] rd_line,
    input  logic                   wr_en,
    input  logic                   wr_way,
    input  logic [WSEL_W-1:0]      wr_word,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic                   fill_en,
    input  logic [IDX_W-1:0]       fill_set,
    input  logic                   fill_way,
    input  logic [LINE_W-1:0]      fill_line
);

    localparam int LBIT_W = $clog2(LINE_W);

    logic [LBIT_W-1:0] wr_base;
    assign wr_base = {wr_word, {($clog2(WORD_W)){1'b0}}};

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [LINE_W-1:0] line_q [SETS];

        always_ff @(posedge clk) begin
            if (fill_en && fill_way == 1'(w))
                line_q[fill_set] <= fill_line;
            else if (wr_en && wr_way == 1'(w))
                line_q[rd_set][wr_base +: WORD_W] <= wr_data;
        end

        assign rd_line[w] = line_q[rd_set];
    end

endmodule

// File: rtl/cache2w_miss_ctrl.sv
module cache2w_miss_ctrl
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = CW_ADDR_W,
    parameter int TAG_W  = 24,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  st_set,
    input  logic [TAG_W-1:0]  st_tag,
    input  logic              st_way,
    input  logic              st_dirty,
    input  logic [TAG_W-1:0]  st_vtag,
    input  logic              mem_ack,
    output miss_state_e       state,
    output logic [IDX_W-1:0]  cur_set,
    output logic              cur_way,
    output logic [TAG_W-1:0]  cur_tag,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              fill_en
);

    logic [TAG_W-1:0] vtag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= MS_IDLE;
            cur_set <= '0;
            cur_way <= 1'b0;
            cur_tag <= '0;
            vtag_q  <= '0;
        end else begin
            case (state)
                MS_IDLE: if (start) begin
                    cur_set <= st_set;
                    cur_way <= st_way;
                    cur_tag <= st_tag;
                    vtag_q  <= st_vtag;
                    state   <= st_dirty ? MS_WBACK : MS_FILL;
                end
                MS_WBACK: if (mem_ack) state <= MS_FILL;
                MS_FILL:  if (mem_ack) state <= MS_DONE;
                default:  state <= MS_IDLE;
            endcase
        end
    end

    assign mem_req  = (state == MS_WBACK) || (state == MS_FILL);
    assign mem_we   = (state == MS_WBACK);
    assign fill_en  = (state == MS_FILL) && mem_ack;
    assign mem_addr = {(mem_we ? vtag_q : cur_tag), cur_set, {OFF_W{1'b0}}};

endmodule

// File: rtl/cache_2way.sv
module cache_2way
    import cache2w_pkg::*;
#(
    parameter int ADDR_W     = CW_ADDR_W,
    parameter int WORD_W     = CW_WORD_W,
    parameter int LINE_WORDS = CW_LINE_WORDS,
    parameter int SETS       = CW_SETS,
    localparam int LINE_W    = WORD_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = BYTE_W + WSEL_W;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LBIT_W = $clog2(LINE_W);

    logic [IDX_W-1:0]  req_set, rd_set, cur_set;
    logic [TAG_W-1:0]  req_tag, cur_tag;
    logic [WSEL_W-1:0] req_word;
    logic [LBIT_W-1:0] rd_base;
    logic              byte_unused;

    logic [1:0]             hit_way, way_vld, way_dty;
    logic [1:0][TAG_W-1:0]  way_tag;
    logic [1:0][LINE_W-1:0] way_line;
    logic                   lru_way, hit, hit_idx, victim, victim_dirty;
    logic                   idle, access, start, cur_way, fill_en;
    miss_state_e            state;

    assign req_set     = cpu_addr[OFF_W +: IDX_W];
    assign req_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_word    = cpu_addr[BYTE_W +: WSEL_W];
    assign byte_unused = ^cpu_addr[BYTE_W-1:0];
    assign rd_base     = {req_word, {($clog2(WORD_W)){1'b0}}};

    assign idle    = (state == MS_IDLE);
    assign rd_set  = idle ? req_set : cur_set;
    assign hit     = |hit_way;
    assign hit_idx = hit_way[1];
    assign access  = idle && cpu_req && hit;
    assign start   = idle && cpu_req && !hit;

    assign victim       = pick_victim(way_vld, lru_way);
    assign victim_dirty = way_vld[victim] && way_dty[victim];

    assign cpu_stall = !idle || (cpu_req && !hit);
    assign cpu_rdata = way_line[hit_idx][rd_base +: WORD_W];
    assign mem_wdata = way_line[cur_way];

    cache2w_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst        (rst),
        .rd_set     (rd_set),
        .rd_tag     (req_tag),
        .hit_way    (hit_way),
        .way_vld    (way_vld),
        .way_dty    (way_dty),
        .way_tag    (way_tag),
        .lru_way    (lru_way),
        .touch_en   (access),
        .touch_way  (hit_idx),
        .touch_dirty(cpu_we),
        .fill_en    (fill_en),
        .fill_set   (cur_set),
        .fill_way   (cur_way),
        .fill_tag   (cur_tag)
    );

    cache2w_data_store #(.SETS(SETS), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_data (
        .clk      (clk),
        .rd_set   (rd_set),
        .rd_line  (way_line),
        .wr_en    (access && cpu_we),
        .wr_way   (hit_idx),
        .wr_word  (req_word),
        .wr_data  (cpu_wdata),
        .fill_en  (fill_en),
        .fill_set (cur_set),
        .fill_way (cur_way),
        .fill_line(mem_rdata)
    );

    cache2w_miss_ctrl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .st_set  (req_set),
        .st_tag  (req_tag),
        .st_way  (victim),
        .st_dirty(victim_dirty),
        .st_vtag (way_tag[victim]),
        .mem_ack (mem_ack),
        .state   (state),
        .cur_set (cur_set),
        .cur_way (cur_way),
        .cur_tag (cur_tag),
        .mem_req (mem_req),
        .mem_we  (mem_we),
        .mem_addr(mem_addr),
        .fill_en (fill_en)
    );

endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_stall,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !mem_req);

    a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_stall) |-> !mem_req);

    a_r6_wb_then_fill: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    a_r8_line_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    a_r8_stall_with_mem: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> cpu_stall);

    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

bind cache_2way cache2w_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_req  (cpu_req),
    .cpu_stall(cpu_stall),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr)
);

// File: tb/cache_2way_bench.sv
`timescale 1ns/1ps
module cache_2way_bench;

    localparam int LAT  = 3;
    localparam int SETS = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst = 1'b1;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
    logic         cpu_stall, mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_ack = 1'b0;

    cache_2way u_cache_2way (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    typedef struct { bit we; logic [31:0] addr; } tx_t;

    int n_vec = 0, n_bad = 0, cnt = 0;
    logic [127:0] bmem  [logic [31:0]];
    logic [31:0]  gold  [logic [31:0]];
    bit           dmod  [logic [31:0]];
    logic [31:0]  rec   [SETS][$];
    tx_t          exp_q [$];

    function automatic logic [31:0] init_word(logic [31:0] wa);
        return wa ^ 32'hA5C3_0F1E;
    endfunction

    function automatic logic [31:0] gold_rd(logic [31:0] wa);
        if (gold.exists(wa)) return gold[wa];
        return init_word(wa);
    endfunction

    function automatic logic [127:0] gold_line(logic [31:0] la);
        logic [127:0] l;
        for (int i = 0; i < 4; i++) l[i*32 +: 32] = gold_rd(la + 32'(4*i));
        return l;
    endfunction

    function automatic logic [127:0] back_rd(logic [31:0] la);
        logic [127:0] l;
        if (bmem.exists(la)) return bmem[la];
        for (int i = 0; i < 4; i++) l[i*32 +: 32] = init_word(la + 32'(4*i));
        return l;
    endfunction

    task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory: each transfer lasts LAT cycles, ack on the last one
    always @(negedge clk) begin
        if (rst || !mem_req) begin
            cnt = 0;
            mem_ack = 1'b0;
        end else if (cnt == LAT-1) begin
            tx_t t;
            cnt = 0;
            mem_ack = 1'b1;
            if (exp_q.size() == 0) begin
                check(0, "R6", "unexpected memory transfer", {mem_we, mem_addr}, 0);
            end else begin
                t = exp_q.pop_front();
                check(mem_we == t.we && mem_addr == t.addr, t.we ? "R6" : "R8",
                      "memory transfer {we,addr}", {mem_we, mem_addr}, {t.we, t.addr});
            end
            if (mem_we) begin
                check(mem_wdata == gold_line(mem_addr), "R6", "evicted line",
                      mem_wdata, gold_line(mem_addr));
                bmem[mem_addr] = mem_wdata;
            end else begin
                mem_rdata = back_rd(mem_addr);
            end
        end else begin
            cnt++;
            mem_ack = 1'b0;
        end
    end

    task automatic access(bit we, logic [31:0] addr, logic [31:0] wd, string req);
        logic [31:0] la, v, exp_rd;
        int s, idx, n, exp_st;
        bit hit, wb;
        la  = {addr[31:4], 4'b0};
        s   = int'(addr[7:4]);
        wb  = 1'b0;
        idx = -1;
        exp_rd = gold_rd({addr[31:2], 2'b0});
        for (int i = 0; i < rec[s].size(); i++) if (rec[s][i] == la) idx = i;
        hit = (idx >= 0);
        if (hit) begin
            rec[s].delete(idx);
        end else begin
            if (rec[s].size() == 2) begin
                v = rec[s][1];
                if (dmod.exists(v) && dmod[v]) begin
                    wb = 1'b1;
                    exp_q.push_back('{1'b1, v});
                end
                void'(rec[s].pop_back());
            end
            exp_q.push_back('{1'b0, la});
            dmod[la] = 1'b0;
        end
        rec[s].push_front(la);
        if (we) begin
            dmod[la] = 1'b1;
            gold[{addr[31:2], 2'b0}] = wd;
        end
        exp_st = hit ? 0 : (LAT + 2 + (wb ? LAT : 0));

        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        n = 0;
        forever begin
            #1;
            if (!cpu_stall || n > 100) break;
            n++;
            @(negedge clk);
        end
        check(n == exp_st, hit ? "R2" : "R8", "stall cycles", n, exp_st);
        if (!we) check(cpu_rdata == exp_rd, req, "read word", cpu_rdata, exp_rd);
        check(exp_q.size() == 0, "R6", "transfers left over", exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL R8 watchdog: actual running expected finished");
        n_vec++; n_bad++;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check(!cpu_stall && !mem_req, "R1", "idle outputs after reset",
              {cpu_stall, mem_req}, 0);

        // set 0: fill, hit, evict, dirty eviction
        access(0, 32'h0000_1000, 0, "R1");   // empty set: miss
        access(0, 32'h0000_2004, 0, "R5");   // second empty way, no eviction
        access(0, 32'h0000_1008, 0, "R2");
        access(0, 32'h0000_2007, 0, "R2");   // byte bits ignored
        access(0, 32'h0000_3000, 0, "R4");   // evicts 0x1000 (older)
        access(0, 32'h0000_200C, 0, "R4");   // 0x2000 kept
        access(1, 32'h0000_2004, 32'hCAFE_0001, "R6");
        access(0, 32'h0000_4000, 0, "R4");   // evicts clean 0x3000
        // set 2 traffic leaves set 0 alone
        access(0, 32'h0000_1020, 0, "R3");
        access(0, 32'h0000_2020, 0, "R3");
        access(0, 32'h0000_3020, 0, "R3");
        access(0, 32'h0000_2004, 0, "R3");   // still cached in set 0
        access(0, 32'h0000_5000, 0, "R6");   // evicts clean 0x4000
        access(0, 32'h0000_6000, 0, "R6");   // evicts dirty 0x2000
        access(0, 32'h0000_2004, 0, "R6");   // written word from memory
        // write allocate
        access(1, 32'h0000_7018, 32'h1234_5678, "R7");
        access(0, 32'h0000_7018, 0, "R7");
        access(0, 32'h0000_7014, 0, "R7");
        access(0, 32'h0000_701C, 0, "R7");

        r = 32'h1357_9BDF;
        for (int k = 0; k < 400; k++) begin
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            access(r[8], {24'(r[1:0]) + 24'h40, 2'b0, r[3:2], r[5:4], r[7:6]}, r, "R4");
        end

        @(negedge clk);
        cpu_req = 1'b0;
        #1;
        check(!cpu_stall && !mem_req, "R1", "idle outputs at end", {cpu_stall, mem_req}, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule